// File: doc/BRIEF.md
# Run-Start Gate with Synchronized Timestamp

This block controls run start and run stop for one trigger unit in a data acquisition chain. A host issues one-cycle command strobes that arm the run, stop it, zero the timestamp, or zero the trigger count. Arming does not open the gate at once. An internal run flag rises only after a fixed number of clock cycles has passed. This leaves time for downstream crate controllers to switch into acquisition mode.

While the run flag is low, both the trigger path and the timestamp tick path are held at zero. This means every timestamp counter that hangs off the gated tick stays frozen and starts counting on the same cycle. When the flag is high, both paths pass their inputs through combinationally.

The block keeps two counters, both fed from the gated paths:
- a timestamp counter that advances on each gated tick;
- a trigger register that counts gated triggers.

Both are visible to the host at all times.

Top module: `run_gate`

## Requirements
- R1: While `go_o` is 0, `trig_o` and `ts_tick_o` are 0 whatever `trig_i` and `ts_tick_i` do.
- R2: While `go_o` is 1, `trig_o` equals `trig_i` and `ts_tick_o` equals `ts_tick_i` in the same cycle.
- R3: An arm command (`cmd_valid_i`=1, `cmd_i`=0) sampled while idle makes `go_o` rise exactly `DELAY_CYCLES` clock edges later.
- R4: An arm command sampled while the delay is counting or while `go_o` is 1 has no effect on `go_o` or on the rise time.
- R5: A stop command (`cmd_i`=1) drives `go_o` to 0 after the next edge. During the delay it cancels the pending rise, so `go_o` stays 0.
- R6: A timestamp clear command (`cmd_i`=2) makes `ts_o` 0 after the next edge, even if a gated tick arrives in the same cycle.
- R7: A trigger clear command (`cmd_i`=3) makes `trig_cnt_o` 0 after the next edge, even if a gated trigger arrives in the same cycle.
- R8: `ts_o` advances by one on each edge where `ts_tick_o` is 1. It wraps from all ones to 0 without any indication.
- R9: `trig_cnt_o` advances by one on each edge where `trig_o` is 1.
- R10: After an asynchronous reset, `go_o`, `ts_o` and `trig_cnt_o` are 0, and the block is idle.
- R11: While `go_o` is 0, `ts_o` and `trig_cnt_o` hold their values, except when a clear command is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Host command strobe, one cycle per command |
| cmd_i | input | 2 | Command code: 0 arm, 1 stop, 2 clear timestamp, 3 clear trigger count |
| trig_i | input | 1 | Raw trigger, synchronous to clk_i |
| ts_tick_i | input | 1 | Timestamp tick, synchronous to clk_i |
| trig_o | output | 1 | Gated trigger |
| ts_tick_o | output | 1 | Gated timestamp tick |
| go_o | output | 1 | Run flag |
| ts_o | output | TS_W | Timestamp counter value |
| trig_cnt_o | output | TRIG_W | Trigger register value |

## Verification
The gated outputs are combinational, so the bench checks `trig_o` and `ts_tick_o` against the inputs driven in the same cycle, a few nanoseconds after driving them. Counter values and the run flag change one edge after the strobe or event that moves them. The one exception is the run flag rising, which is due `DELAY_CYCLES` edges after the arm strobe edge.

Each table row drives its inputs shortly after a rising edge. It then compares the outputs against the state the earlier rows should have produced, before the next edge. With `DELAY_CYCLES`=4, this puts the run flag at 0 for the four rows after the arm row and at 1 on the fifth. Directed tests also check the timestamp wrap and an asynchronous reset in the middle of a run.

// File: rtl/run_gate_pkg.sv
package run_gate_pkg;
  typedef enum logic [1:0] {
    CMD_ARM      = 2'd0,
    CMD_STOP     = 2'd1,
    CMD_CLR_TS   = 2'd2,
    CMD_CLR_TRIG = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    RUN_IDLE = 2'd0,
    RUN_WAIT = 2'd1,
    RUN_GO   = 2'd2
  } run_state_e;
endpackage

// File: rtl/run_ctrl.sv
module run_ctrl
  import run_gate_pkg::*;
#(
  parameter int unsigned DELAY_CYCLES = 12500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  cmd_e cmd_i,
  output logic go_o
);
  localparam int unsigned CNT_W = $clog2(DELAY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY_CYCLES - 1);

  run_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  wire arm_cmd  = cmd_valid_i && (cmd_i == CMD_ARM);
  wire stop_cmd = cmd_valid_i && (cmd_i == CMD_STOP);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      RUN_IDLE: if (arm_cmd) begin
        state_d = RUN_WAIT;
        cnt_d   = LOAD;
      end
      RUN_WAIT: begin
        if (stop_cmd)            state_d = RUN_IDLE;   // cancel pending rise
        else if (cnt_q == '0)    state_d = RUN_GO;
        else                     cnt_d   = cnt_q - 1'b1;
      end
      RUN_GO:   if (stop_cmd) state_d = RUN_IDLE;
      default:  state_d = RUN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RUN_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign go_o = (state_q == RUN_GO);

  // independent count of cycles spent waiting, for checking only
  logic [CNT_W-1:0] waited_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 waited_q <= '0;
    else if (state_q == RUN_WAIT) waited_q <= waited_q + 1'b1;
    else                         waited_q <= '0;
  end

  p_delay_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(go_o) |-> waited_q == CNT_W'(DELAY_CYCLES));
  p_arm_ignored_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && arm_cmd) |=> go_o);
  p_stop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_cmd |=> !go_o);
endmodule

// File: rtl/event_counter.sv
module event_counter #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;          // clear wins over increment
    else if (inc_i) cnt_q <= cnt_q + 1'b1; // wraps silently
  end

  assign cnt_o = cnt_q;

  p_clear_r6_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
  p_step_r8_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i) |=> cnt_o == W'($past(cnt_o) + 1'b1));
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/run_gate.sv
module run_gate
  import run_gate_pkg::*;
#(
  parameter int unsigned DELAY_CYCLES = 12500,
  parameter int unsigned TS_W         = 48,
  parameter int unsigned TRIG_W       = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic              trig_i,
  input  logic              ts_tick_i,
  output logic              trig_o,
  output logic              ts_tick_o,
  output logic              go_o,
  output logic [TS_W-1:0]   ts_o,
  output logic [TRIG_W-1:0] trig_cnt_o
);
  cmd_e cmd;
  logic go;
  assign cmd = cmd_e'(cmd_i);

  run_ctrl #(.DELAY_CYCLES(DELAY_CYCLES)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_i      (cmd),
    .go_o       (go)
  );

  assign trig_o    = trig_i & go;
  assign ts_tick_o = ts_tick_i & go;
  assign go_o      = go;

  event_counter #(.W(TS_W)) u_ts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cmd_valid_i && (cmd == CMD_CLR_TS)),
    .inc_i (ts_tick_o),
    .cnt_o (ts_o)
  );

  event_counter #(.W(TRIG_W)) u_trig (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cmd_valid_i && (cmd == CMD_CLR_TRIG)),
    .inc_i (trig_o),
    .cnt_o (trig_cnt_o)
  );

  p_gate_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !go_o |-> (!trig_o && !ts_tick_o));
  p_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |-> (trig_o == trig_i && ts_tick_o == ts_tick_i));
  p_frozen_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!go_o && !cmd_valid_i) |=> ($stable(ts_o) && $stable(trig_cnt_o)));
endmodule

// File: tb/run_gate_tb.sv
module run_gate_tb;
  localparam int unsigned DLY = 4;
  localparam int unsigned TW  = 8;

  typedef struct packed {
    logic       v;
    logic [1:0] c;
    logic       t;
    logic       k;
    logic       go;
    logic       to;
    logic       ko;
    logic [7:0] ts;
    logic [7:0] tc;
  } vec_t;

  // rows: strobe, cmd, trig, tick | expected go, trig_o, tick_o, ts, count (state before this row's edge)
  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b0,2'd0,1'b1,1'b1, 1'b0,1'b0,1'b0, 8'd0,8'd0}, // 0  R1 blocked
    '{1'b1,2'd0,1'b1,1'b1, 1'b0,1'b0,1'b0, 8'd0,8'd0}, // 1  arm
    '{1'b0,2'd0,1'b1,1'b1, 1'b0,1'b0,1'b0, 8'd0,8'd0}, // 2  R3 waiting
    '{1'b0,2'd0,1'b0,1'b1, 1'b0,1'b0,1'b0, 8'd0,8'd0}, // 3
    '{1'b0,2'd0,1'b1,1'b0, 1'b0,1'b0,1'b0, 8'd0,8'd0}, // 4
    '{1'b1,2'd0,1'b1,1'b1, 1'b0,1'b0,1'b0, 8'd0,8'd0}, // 5  R4 arm in wait
    '{1'b0,2'd0,1'b1,1'b1, 1'b1,1'b1,1'b1, 8'd0,8'd0}, // 6  R3 go up, R2
    '{1'b0,2'd0,1'b0,1'b1, 1'b1,1'b0,1'b1, 8'd1,8'd1}, // 7  R8 R9
    '{1'b0,2'd0,1'b1,1'b0, 1'b1,1'b1,1'b0, 8'd2,8'd1}, // 8
    '{1'b1,2'd0,1'b1,1'b1, 1'b1,1'b1,1'b1, 8'd2,8'd2}, // 9  R4 arm in run
    '{1'b1,2'd2,1'b1,1'b1, 1'b1,1'b1,1'b1, 8'd3,8'd3}, // 10 R6 clear ts vs tick
    '{1'b1,2'd3,1'b1,1'b1, 1'b1,1'b1,1'b1, 8'd0,8'd4}, // 11 R7 clear trig vs trig
    '{1'b0,2'd0,1'b0,1'b0, 1'b1,1'b0,1'b0, 8'd1,8'd0}, // 12
    '{1'b1,2'd1,1'b1,1'b1, 1'b1,1'b1,1'b1, 8'd1,8'd0}, // 13 R5 stop
    '{1'b0,2'd0,1'b1,1'b1, 1'b0,1'b0,1'b0, 8'd2,8'd1}, // 14 R11 frozen
    '{1'b1,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0, 8'd2,8'd1}, // 15 arm again
    '{1'b0,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0, 8'd2,8'd1}, // 16
    '{1'b1,2'd1,1'b0,1'b0, 1'b0,1'b0,1'b0, 8'd2,8'd1}, // 17 R5 cancel
    '{1'b0,2'd0,1'b1,1'b1, 1'b0,1'b0,1'b0, 8'd2,8'd1}, // 18
    '{1'b0,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0, 8'd2,8'd1}, // 19
    '{1'b0,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0, 8'd2,8'd1}, // 20 R5 still low
    '{1'b1,2'd2,1'b0,1'b0, 1'b0,1'b0,1'b0, 8'd2,8'd1}, // 21 R6 clear while idle
    '{1'b0,2'd0,1'b0,1'b0, 1'b0,1'b0,1'b0, 8'd0,8'd1}  // 22
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [1:0] cmd_i = 2'd0;
  logic trig_i = 1'b0;
  logic ts_tick_i = 1'b0;
  logic trig_o, ts_tick_o, go_o;
  logic [TW-1:0] ts_o;
  logic [TW-1:0] trig_cnt_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  run_gate #(.DELAY_CYCLES(DLY), .TS_W(TW), .TRIG_W(TW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .trig_i(trig_i), .ts_tick_i(ts_tick_i), .trig_o(trig_o), .ts_tick_o(ts_tick_o),
    .go_o(go_o), .ts_o(ts_o), .trig_cnt_o(trig_cnt_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] c, input logic t, input logic k);
    cmd_valid_i = v; cmd_i = c; trig_i = t; ts_tick_i = k;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
      finish_run();
    end
  end

  initial begin
    drive(1'b0, 2'd0, 1'b1, 1'b1);
    repeat (3) @(posedge clk_i);
    #4;
    chk("R10 go", go_o, 0);
    chk("R10 ts", ts_o, 0);
    chk("R10 cnt", trig_cnt_o, 0);
    chk("R1 trig in reset", trig_o, 0);
    drive(1'b0, 2'd0, 1'b0, 1'b0);
    #3 rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(posedge clk_i); #2;
      drive(VECS[i].v, VECS[i].c, VECS[i].t, VECS[i].k);
      #3;
      chk($sformatf("R1/R2/R3 go row %0d", i), go_o, VECS[i].go);
      chk($sformatf("R1/R2 trig_o row %0d", i), trig_o, VECS[i].to);
      chk($sformatf("R1/R2 tick_o row %0d", i), ts_tick_o, VECS[i].ko);
      chk($sformatf("R6/R8/R11 ts row %0d", i), ts_o, VECS[i].ts);
      chk($sformatf("R7/R9/R11 count row %0d", i), trig_cnt_o, VECS[i].tc);
    end

    // R8 wrap: arm, wait, clear, then 256 ticks
    @(posedge clk_i); #2 drive(1'b1, 2'd0, 1'b0, 1'b0);
    @(posedge clk_i); #2 drive(1'b0, 2'd0, 1'b0, 1'b0);
    repeat (DLY - 1) @(posedge clk_i);
    #2 chk("R3 go still low at delay-1", go_o, 0);
    @(posedge clk_i); #2 chk("R3 go high at delay", go_o, 1);
    drive(1'b1, 2'd2, 1'b0, 1'b0);
    @(posedge clk_i); #2 drive(1'b0, 2'd0, 1'b0, 1'b1);
    chk("R6 ts cleared", ts_o, 0);
    repeat (255) @(posedge clk_i);
    #2 chk("R8 ts at max", ts_o, 255);
    @(posedge clk_i); #2 chk("R8 ts wrapped", ts_o, 0);
    drive(1'b0, 2'd0, 1'b1, 1'b0);
    @(posedge clk_i); #2 chk("R9 count step", trig_cnt_o, 2);

    // R10 reset mid-run
    #3 rst_ni = 1'b0;
    #2;
    chk("R10 go after reset", go_o, 0);
    chk("R10 ts after reset", ts_o, 0);
    chk("R10 cnt after reset", trig_cnt_o, 0);
    chk("R1 trig_o after reset", trig_o, 0);
    drive(1'b0, 2'd0, 1'b0, 1'b0);
    @(posedge clk_i); #3 rst_ni = 1'b1;
    repeat (DLY + 2) @(posedge clk_i);
    #2 chk("R10 idle after reset", go_o, 0);

    done = 1'b1;
    finish_run();
  end
endmodule